// File: doc/BRIEF.md
# Pulse-Counting Ramp Converter Controller

This block is the digital half of a pair of ramp converters. On the input side it drives a charge-sharing ramp DAC: given an 8-bit code, it first clears the ramp and then emits that many one-cycle charge pulses. Each pulse raises the analog level by one step of about 2.34 mV, so a full-scale code gives about 600 mV. On the output side it drives a single-slope ADC. It clears a second ramp, then emits ramp pulses one at a time. Between pulses it samples a comparator that reports whether the ramp has passed the held analog level.

The number of pulses emitted before the comparator trips is the raw count. A calibration offset, loaded through a small write port, is subtracted from that count. The difference is clamped at zero and returned with a one-cycle valid strobe. If the comparator never trips, the count stops at full scale and the result is full scale with no correction. Each side has its own end-of-conversion level, which stays high until that side accepts its next start. The ramps and the comparator themselves are analog and lie outside this block.

Top module: `ramp_conv_ctrl`

## Requirements
- R1: After a synchronous reset, every output is low, the result is zero and the stored offset is zero.
- R2: An accepted DAC start with code N produces exactly N pulses on `dac_pulse`. Each pulse is high for one cycle and followed by at least one low cycle.
- R3: On each side, the clock edge that accepts a start raises that side's ramp-reset output for exactly one cycle. No pulse is high during that cycle, and the first pulse follows it directly.
- R4: `dac_eoc` rises on the 2N+1-th clock edge after the edge that accepted a DAC start with code N. For code zero, this is the edge right after the ramp-reset cycle.
- R5: Each end-of-conversion output stays high after completion until the edge that accepts that side's next start, and it goes low on that edge.
- R6: A start that arrives while its side is converting is ignored. The code, the pulse count and the timing of the running conversion are unchanged.
- R7: The ADC samples `adc_cmp` on the edge that ends each low cycle after a pulse. If the comparator is high there, the conversion finishes on that edge with a raw count equal to the pulses emitted so far. `adc_valid` is high for exactly that one cycle, together with the rising `adc_eoc`.
- R8: A cycle with `cal_load` high stores `cal_value` as the offset. A conversion that finishes after that edge reports the raw count minus the stored offset.
- R9: When the stored offset is greater than or equal to the raw count, the result is zero, never a wrapped value.
- R10: If the comparator is still low after 255 pulses, the conversion ends on the next sampling edge and the result is 255, regardless of the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dac_start | input | 1 | Begin a DAC conversion (accepted only when that side is idle) |
| dac_code | input | CODE_W | Number of charge pulses to emit |
| dac_pulse | output | 1 | Charge pulse to the DAC ramp |
| dac_ramp_rst | output | 1 | Clears the DAC ramp before the first pulse |
| dac_eoc | output | 1 | DAC conversion finished (level) |
| adc_start | input | 1 | Begin an ADC conversion (accepted only when that side is idle) |
| adc_cmp | input | 1 | Comparator: high once the ramp exceeds the held level |
| adc_pulse | output | 1 | Step pulse to the ADC ramp |
| adc_ramp_rst | output | 1 | Clears the ADC ramp before the first pulse |
| adc_eoc | output | 1 | ADC conversion finished (level) |
| adc_valid | output | 1 | One-cycle strobe marking a new result |
| adc_result | output | CODE_W | Offset-corrected, clamped count |
| cal_load | input | 1 | Store `cal_value` as the offset |
| cal_value | input | CODE_W | Calibration offset in codes |

## Verification
A remaining-pulse counter that is off by one shows on `dac_pulse` and `dac_eoc` within two cycles of the step where the count goes wrong. A phase register stuck in a busy state leaves the end-of-conversion level low, and the reference model flags that on the first cycle it differs. An ADC count that drifts from the pulses actually sent makes the comparator trip against the wrong number, which is visible in `adc_result` on the same edge as `adc_valid`. A corrupted offset register stays hidden until the next conversion finishes, so every offset change is followed by a conversion near the clamp boundary.

// File: rtl/ramp_conv_pkg.sv
package ramp_conv_pkg;
  // Phases shared by both ramp sequencers
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CLEAR = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } ramp_phase_t;
endpackage

// File: rtl/offset_trim.sv
module offset_trim
  import ramp_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_load,
  input  logic [CODE_W-1:0] cal_value,
  input  logic [CODE_W-1:0] raw_count,
  output logic [CODE_W-1:0] trimmed
);
  logic [CODE_W-1:0] offset_q;

  always_ff @(posedge clk) begin
    if (rst)           offset_q <= '0;
    else if (cal_load) offset_q <= cal_value;
  end

  // Subtract with clamp at zero (R9)
  always_comb begin
    if (raw_count > offset_q) trimmed = raw_count - offset_q;
    else                      trimmed = '0;
  end

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    trimmed <= raw_count);
endmodule

// File: rtl/ramp_dac_seq.sv
module ramp_dac_seq
  import ramp_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              pulse,
  output logic              ramp_rst,
  output logic              eoc
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  ramp_phase_t       ph;
  logic [CODE_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      left     <= '0;
      pulse    <= 1'b0;
      ramp_rst <= 1'b0;
      eoc      <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph       <= PH_CLEAR;
            ramp_rst <= 1'b1;
            eoc      <= 1'b0;
            left     <= code;
          end
        end
        PH_CLEAR: begin
          ramp_rst <= 1'b0;
          if (left == '0) begin
            ph  <= PH_IDLE;
            eoc <= 1'b1;
          end else begin
            ph    <= PH_HIGH;
            pulse <= 1'b1;
            left  <= left - ONE;
          end
        end
        PH_HIGH: begin
          pulse <= 1'b0;
          ph    <= PH_LOW;
        end
        default: begin
          if (left == '0) begin
            ph  <= PH_IDLE;
            eoc <= 1'b1;
          end else begin
            ph    <= PH_HIGH;
            pulse <= 1'b1;
            left  <= left - ONE;
          end
        end
      endcase
    end
  end

  a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  a_r3_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ramp_rst |=> !ramp_rst);
  a_r3_no_pulse_in_clear: assert property (@(posedge clk) disable iff (rst)
    ramp_rst |-> !pulse);
  a_r5_eoc_holds: assert property (@(posedge clk) disable iff (rst)
    (eoc && !start) |=> eoc);
  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (!eoc && !ramp_rst && ph != PH_IDLE && start) |=> !ramp_rst);
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmp,
  input  logic [CODE_W-1:0] trimmed,
  output logic [CODE_W-1:0] count,
  output logic              pulse,
  output logic              ramp_rst,
  output logic              eoc,
  output logic              valid,
  output logic [CODE_W-1:0] data
);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  ramp_phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      count    <= '0;
      pulse    <= 1'b0;
      ramp_rst <= 1'b0;
      eoc      <= 1'b0;
      valid    <= 1'b0;
      data     <= '0;
    end else begin
      valid <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph       <= PH_CLEAR;
            ramp_rst <= 1'b1;
            eoc      <= 1'b0;
            count    <= '0;
          end
        end
        PH_CLEAR: begin
          ramp_rst <= 1'b0;
          pulse    <= 1'b1;
          count    <= count + ONE;
          ph       <= PH_HIGH;
        end
        PH_HIGH: begin
          pulse <= 1'b0;
          ph    <= PH_LOW;
        end
        default: begin
          if (cmp) begin
            data  <= trimmed;
            valid <= 1'b1;
            eoc   <= 1'b1;
            ph    <= PH_IDLE;
          end else if (count == MAX_CODE) begin
            data  <= MAX_CODE;
            valid <= 1'b1;
            eoc   <= 1'b1;
            ph    <= PH_IDLE;
          end else begin
            pulse <= 1'b1;
            count <= count + ONE;
            ph    <= PH_HIGH;
          end
        end
      endcase
    end
  end

  a_r7_valid_with_eoc: assert property (@(posedge clk) disable iff (rst)
    valid |-> eoc);
  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  a_r3_clear_then_pulse: assert property (@(posedge clk) disable iff (rst)
    ramp_rst |=> pulse);
  a_r9_result_within_count: assert property (@(posedge clk) disable iff (rst)
    valid |-> data <= count);
  a_r10_saturate_full: assert property (@(posedge clk) disable iff (rst)
    (valid && !$past(cmp)) |-> data == MAX_CODE);
endmodule

// File: rtl/ramp_conv_ctrl.sv
module ramp_conv_ctrl
  import ramp_conv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dac_start,
  input  logic [CODE_W-1:0] dac_code,
  output logic              dac_pulse,
  output logic              dac_ramp_rst,
  output logic              dac_eoc,
  input  logic              adc_start,
  input  logic              adc_cmp,
  output logic              adc_pulse,
  output logic              adc_ramp_rst,
  output logic              adc_eoc,
  output logic              adc_valid,
  output logic [CODE_W-1:0] adc_result,
  input  logic              cal_load,
  input  logic [CODE_W-1:0] cal_value
);
  logic [CODE_W-1:0] raw_count;
  logic [CODE_W-1:0] trimmed;

  ramp_dac_seq #(.CODE_W(CODE_W)) u_dac (
    .clk      (clk),
    .rst      (rst),
    .start    (dac_start),
    .code     (dac_code),
    .pulse    (dac_pulse),
    .ramp_rst (dac_ramp_rst),
    .eoc      (dac_eoc)
  );

  offset_trim #(.CODE_W(CODE_W)) u_trim (
    .clk       (clk),
    .rst       (rst),
    .cal_load  (cal_load),
    .cal_value (cal_value),
    .raw_count (raw_count),
    .trimmed   (trimmed)
  );

  ramp_adc_seq #(.CODE_W(CODE_W)) u_adc (
    .clk      (clk),
    .rst      (rst),
    .start    (adc_start),
    .cmp      (adc_cmp),
    .trimmed  (trimmed),
    .count    (raw_count),
    .pulse    (adc_pulse),
    .ramp_rst (adc_ramp_rst),
    .eoc      (adc_eoc),
    .valid    (adc_valid),
    .data     (adc_result)
  );
endmodule

// File: tb/ramp_conv_ctrl_tb.sv
module ramp_conv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dac_start = 1'b0, adc_start = 1'b0, adc_cmp = 1'b0, cal_load = 1'b0;
  logic [CODE_W-1:0] dac_code = '0, cal_value = '0;
  logic dac_pulse, dac_ramp_rst, dac_eoc;
  logic adc_pulse, adc_ramp_rst, adc_eoc, adc_valid;
  logic [CODE_W-1:0] adc_result;

  int checks = 0, fails = 0;
  int samp = 0;
  int dpc = 0;

  ramp_conv_ctrl #(.CODE_W(CODE_W)) u_dut (
    .clk(clk), .rst(rst),
    .dac_start(dac_start), .dac_code(dac_code),
    .dac_pulse(dac_pulse), .dac_ramp_rst(dac_ramp_rst), .dac_eoc(dac_eoc),
    .adc_start(adc_start), .adc_cmp(adc_cmp),
    .adc_pulse(adc_pulse), .adc_ramp_rst(adc_ramp_rst), .adc_eoc(adc_eoc),
    .adc_valid(adc_valid), .adc_result(adc_result),
    .cal_load(cal_load), .cal_value(cal_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: elapsed-cycle counters per side
  bit m_dbusy = 0, m_abusy = 0;
  int m_dt = 0, m_dn = 0, m_at = 0, m_ak = 0, m_off = 0;
  bit e_dp = 0, e_dr = 0, e_de = 0, e_ap = 0, e_ar = 0, e_ae = 0, e_av = 0;
  int e_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_dbusy = 0; m_abusy = 0; m_dt = 0; m_dn = 0; m_at = 0; m_ak = 0; m_off = 0;
      e_dp = 0; e_dr = 0; e_de = 0; e_ap = 0; e_ar = 0; e_ae = 0; e_av = 0; e_res = 0;
    end else begin
      e_av = 0;
      if (!m_dbusy) begin
        if (dac_start) begin m_dbusy = 1; m_dt = 0; m_dn = int'(dac_code); e_de = 0; end
      end else begin
        m_dt++;
        if (m_dt == 2*m_dn + 1) begin m_dbusy = 0; e_de = 1; end
      end
      e_dr = m_dbusy && (m_dt == 0);
      e_dp = m_dbusy && (m_dt % 2 == 1);
      if (!m_abusy) begin
        if (adc_start) begin m_abusy = 1; m_at = 0; m_ak = 0; e_ae = 0; end
      end else begin
        m_at++;
        if (m_at == 1) m_ak = 1;
        else if (m_at % 2 == 1) begin
          if (adc_cmp || m_ak == 255) begin
            m_abusy = 0; e_ae = 1; e_av = 1;
            e_res = adc_cmp ? ((m_ak > m_off) ? m_ak - m_off : 0) : 255;
          end else m_ak++;
        end
      end
      e_ar = m_abusy && (m_at == 0);
      e_ap = m_abusy && (m_at % 2 == 1);
      if (cal_load) m_off = int'(cal_value);
    end
  end

  // Per-cycle comparison, analog ramp/comparator model and pulse counter
  always @(negedge clk) begin
    chk("R2 dac_pulse", int'(dac_pulse), int'(e_dp));
    chk("R3 dac_ramp_rst", int'(dac_ramp_rst), int'(e_dr));
    chk("R4 dac_eoc", int'(dac_eoc), int'(e_de));
    chk("R7 adc_pulse", int'(adc_pulse), int'(e_ap));
    chk("R3 adc_ramp_rst", int'(adc_ramp_rst), int'(e_ar));
    chk("R5 adc_eoc", int'(adc_eoc), int'(e_ae));
    chk("R7 adc_valid", int'(adc_valid), int'(e_av));
    chk("R8 adc_result", int'(adc_result), e_res);
    adc_cmp = (m_ak > samp);
    if (dac_ramp_rst) dpc = 0;
    else if (dac_pulse) dpc++;
  end

  task automatic dac_run(input int code, input int busy_code);
    @(negedge clk); dac_start = 1'b1; dac_code = CODE_W'(code);
    @(negedge clk); dac_start = 1'b0;
    if (busy_code >= 0) begin
      repeat (3) @(negedge clk);
      dac_start = 1'b1; dac_code = CODE_W'(busy_code);
      @(negedge clk); dac_start = 1'b0;
    end
    while (!dac_eoc) @(negedge clk);
    chk(busy_code >= 0 ? "R6 pulses with busy start" : "R2 pulse count", dpc, code);
  endtask

  task automatic adc_run(input string tag, input int s, input int exp);
    samp = s;
    @(negedge clk); adc_start = 1'b1;
    @(negedge clk); adc_start = 1'b0;
    while (!adc_eoc) @(negedge clk);
    chk(tag, int'(adc_result), exp);
  endtask

  task automatic set_cal(input int v);
    @(negedge clk); cal_load = 1'b1; cal_value = CODE_W'(v);
    @(negedge clk); cal_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dac_pulse", int'(dac_pulse), 0);
    chk("R1 dac_eoc", int'(dac_eoc), 0);
    chk("R1 adc_eoc", int'(adc_eoc), 0);
    chk("R1 adc_result", int'(adc_result), 0);
    rst = 1'b0;
    dac_run(0, -1);      // R4 zero code
    dac_run(1, -1);
    dac_run(5, -1);
    dac_run(10, 3);      // R6
    repeat (4) @(negedge clk);
    chk("R5 dac_eoc held", int'(dac_eoc), 1);
    dac_run(255, -1);
    adc_run("R7 count no offset", 20, 21);
    adc_run("R7 smallest count", 0, 1);
    set_cal(3);
    adc_run("R8 offset removed", 20, 18);
    adc_run("R9 clamp below", 1, 0);
    adc_run("R9 clamp equal", 2, 0);
    adc_run("R8 top trip", 254, 252);
    adc_run("R10 saturation", 400, 255);
    repeat (3) @(negedge clk);
    chk("R5 adc_eoc held", int'(adc_eoc), 1);
    fork
      dac_run(7, -1);
      adc_run("R8 concurrent", 9, 7);
    join
    set_cal(0);
    adc_run("R8 offset cleared", 9, 10);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule